// File: doc/BRIEF.md
# Serial Flash Status and Write Guard

This block keeps the status byte of a serial flash device and rules on every command that would change the array or the status byte. A command decoder upstream turns each received opcode into a one-cycle strobe. The block answers each modifying strobe with a one-cycle accept or reject pulse. It also keeps the busy flag until the array engine signals completion.

Two mechanisms guard the device. The first is a write-enable latch that software arms before each change. The second is a status-lock bit that works with the write-protect pin: while the bit is set and the pin is held low, the status byte is frozen. The three protect-level bits cover a slice of sectors at the top of the address space whose size grows by powers of two. A parameter can move that slice to the bottom of the space instead. The block also holds an auxiliary-region mode flag that is entered and left by two commands. Those commands are ignored while the device is busy.

Top module: `flash_wprot_top`

## Requirements
- R1: After reset, the status byte is 00h, the auxiliary mode flag is 0, and neither accept nor reject is high.
- R2: The enable strobe sets status bit 1 (the write-enable latch) on the next cycle. The disable strobe clears it on the next cycle.
- R3: A program, sector-erase, chip-erase or status-write strobe issued while status bit 1 is 0 gives a reject pulse and leaves the status byte unchanged.
- R4: Each modifying strobe gives exactly one of accept or reject, one cycle after the strobe. Accept and reject are never high together.
- R5: An accepted status write loads status bit 7 from data bit 7 and bits 4..2 from data bits 4..2. Bits 6..5 always read 0. Bits 1..0 never take data, and bit 0 (busy) becomes 1.
- R6: While status bit 7 is 1 and wp_n is 0, a status write is rejected even with the latch set.
- R7: The sector index is addr[21:16]. Protect level k=bits 4..2 protects no sector when k is 0, and otherwise the top min(2^(k-1),64) sectors. A program or sector erase aimed at a protected sector is rejected and does not set busy. A chip erase is rejected when k is non-zero.
- R8: While status bit 0 is 1, every modifying strobe is rejected.
- R9: op_done while busy clears bits 0 and 1 and pulses wel_clear in the same cycle as those bits fall. op_done while idle changes nothing.
- R10: The enter strobe sets mode_aux and the exit strobe clears it. Both are ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wren | input | 1 | Write-enable strobe |
| cmd_wrdi | input | 1 | Write-disable strobe |
| cmd_wrsr | input | 1 | Status-write strobe |
| cmd_pp | input | 1 | Page program strobe |
| cmd_se | input | 1 | Sector erase strobe |
| cmd_ce | input | 1 | Chip erase strobe |
| cmd_aux_on | input | 1 | Enter auxiliary mode strobe |
| cmd_aux_off | input | 1 | Leave auxiliary mode strobe |
| wr_data | input | 8 | Data byte for a status write |
| addr | input | ADDR_W | Target byte address |
| wp_n | input | 1 | Write-protect pin, active low |
| op_done | input | 1 | Completion pulse from the array engine |
| status | output | 8 | Status byte, readable at any time |
| accept | output | 1 | Modifying command accepted |
| reject | output | 1 | Modifying command refused |
| wel_clear | output | 1 | Latch auto-clear pulse on completion |
| mode_aux | output | 1 | Auxiliary region mode flag |

## Verification
The hardest corner to reach is the full product of protect level and sector index. Every level must be written through an accepted status write and its completion. After that, every sector is probed with both program and erase, each armed by its own enable. A bad boundary shows up only at one level and one sector. The bench therefore walks all 8 levels against all 64 sectors. It closes each accepted probe with op_done and each refused probe with a disable strobe. Busy-time rejection and the ignored mode commands are reached by pausing mid-operation before op_done.

// File: rtl/flash_wprot_pkg.sv
package flash_wprot_pkg;
   localparam int unsigned LVL_W = 3;

   typedef struct packed {
      logic             lock;
      logic [1:0]       zero;
      logic [LVL_W-1:0] lvl;
      logic             wel;
      logic             busy;
   } fstat_t;
endpackage

// File: rtl/flash_wprot_range.sv
module flash_wprot_range
   import flash_wprot_pkg::*;
#(
   parameter int unsigned ADDR_W      = 22,
   parameter int unsigned SECT_W      = 16,
   parameter bit          PROTECT_TOP = 1'b1
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [LVL_W-1:0]  lvl_i,
   output logic              hit_o
);
   localparam int unsigned NS_W  = ADDR_W - SECT_W;
   localparam int unsigned NSECT = 1 << NS_W;

   initial begin : param_chk
      assert (ADDR_W > SECT_W) else $error("ADDR_W must exceed SECT_W");
      assert (NS_W <= 16) else $error("sector index too wide");
   end

   logic [NS_W-1:0] sect;
   logic [NS_W:0]   cnt;

   assign sect = addr_i[ADDR_W-1:SECT_W];

   always_comb begin
      if (lvl_i == '0)
         cnt = '0;
      else if (int'(lvl_i) - 1 >= int'(NS_W))
         cnt = (NS_W+1)'(NSECT);
      else
         cnt = (NS_W+1)'(1) << (lvl_i - LVL_W'(1));
   end

   generate
      if (PROTECT_TOP) begin : g_top
         assign hit_o = (cnt != '0) && ({1'b0, sect} >= ((NS_W+1)'(NSECT) - cnt));
      end else begin : g_bottom
         assign hit_o = {1'b0, sect} < cnt;
      end
   endgenerate
endmodule

// File: rtl/flash_wprot_gate.sv
module flash_wprot_gate
   import flash_wprot_pkg::*;
(
   input  logic             wel_i,
   input  logic             busy_i,
   input  logic             lock_i,
   input  logic             wp_n_i,
   input  logic [LVL_W-1:0] lvl_i,
   input  logic             hit_i,
   input  logic             wrsr_i,
   input  logic             ce_i,
   output logic             ok_o
);
   logic rule_ok;

   always_comb begin
      if (wrsr_i)
         rule_ok = !(lock_i && !wp_n_i);
      else if (ce_i)
         rule_ok = (lvl_i == '0);
      else
         rule_ok = !hit_i;
   end

   assign ok_o = wel_i && !busy_i && rule_ok;
endmodule

// File: rtl/flash_wprot_regs.sv
module flash_wprot_regs
   import flash_wprot_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       set_wel_i,
   input  logic       clr_wel_i,
   input  logic       start_i,
   input  logic       load_i,
   input  logic [7:0] data_i,
   input  logic       done_i,
   input  logic       aux_on_i,
   input  logic       aux_off_i,
   output fstat_t     stat_o,
   output logic       wel_clear_o,
   output logic       aux_o
);
   logic             busy_q, wel_q, lock_q, aux_q, clr_q;
   logic [LVL_W-1:0] lvl_q;
   logic             finish;

   assign finish = done_i && busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         wel_q  <= 1'b0;
         lock_q <= 1'b0;
         lvl_q  <= '0;
         aux_q  <= 1'b0;
         clr_q  <= 1'b0;
      end else begin
         clr_q <= finish;
         if (finish) begin
            busy_q <= 1'b0;
            wel_q  <= 1'b0;
         end else begin
            if (start_i) busy_q <= 1'b1;
            if (set_wel_i) wel_q <= 1'b1;
            else if (clr_wel_i) wel_q <= 1'b0;
         end
         if (load_i) begin
            lock_q <= data_i[7];
            lvl_q  <= data_i[4:2];
         end
         if (!busy_q) begin
            if (aux_on_i) aux_q <= 1'b1;
            else if (aux_off_i) aux_q <= 1'b0;
         end
      end
   end

   assign stat_o      = '{lock: lock_q, zero: 2'b00, lvl: lvl_q, wel: wel_q, busy: busy_q};
   assign wel_clear_o = clr_q;
   assign aux_o       = aux_q;

   assert_clear_consistent_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wel_clear_o |-> (!wel_q && !busy_q));
   assert_wren_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (set_wel_i && !finish) |=> wel_q);
   assert_aux_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((aux_on_i || aux_off_i) && busy_q) |=> $stable(aux_q));
endmodule

// File: rtl/flash_wprot_top.sv
module flash_wprot_top
   import flash_wprot_pkg::*;
#(
   parameter int unsigned ADDR_W      = 22,
   parameter int unsigned SECT_W      = 16,
   parameter bit          PROTECT_TOP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wren,
   input  logic              cmd_wrdi,
   input  logic              cmd_wrsr,
   input  logic              cmd_pp,
   input  logic              cmd_se,
   input  logic              cmd_ce,
   input  logic              cmd_aux_on,
   input  logic              cmd_aux_off,
   input  logic [7:0]        wr_data,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wp_n,
   input  logic              op_done,
   output logic [7:0]        status,
   output logic              accept,
   output logic              reject,
   output logic              wel_clear,
   output logic              mode_aux
);
   fstat_t stat;
   logic   hit, ok, modify, go, acc_q, rej_q;

   assign modify = cmd_wrsr || cmd_pp || cmd_se || cmd_ce;
   assign go     = modify && ok;

   flash_wprot_range #(
      .ADDR_W(ADDR_W), .SECT_W(SECT_W), .PROTECT_TOP(PROTECT_TOP)
   ) range_i (
      .addr_i(addr), .lvl_i(stat.lvl), .hit_o(hit)
   );

   flash_wprot_gate gate_i (
      .wel_i(stat.wel), .busy_i(stat.busy), .lock_i(stat.lock), .wp_n_i(wp_n),
      .lvl_i(stat.lvl), .hit_i(hit), .wrsr_i(cmd_wrsr), .ce_i(cmd_ce), .ok_o(ok)
   );

   flash_wprot_regs regs_i (
      .clk(clk), .rst_n(rst_n), .set_wel_i(cmd_wren), .clr_wel_i(cmd_wrdi),
      .start_i(go), .load_i(go && cmd_wrsr), .data_i(wr_data), .done_i(op_done),
      .aux_on_i(cmd_aux_on), .aux_off_i(cmd_aux_off),
      .stat_o(stat), .wel_clear_o(wel_clear), .aux_o(mode_aux)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= 1'b0;
         rej_q <= 1'b0;
      end else begin
         acc_q <= go;
         rej_q <= modify && !ok;
      end
   end

   assign accept = acc_q;
   assign reject = rej_q;
   assign status = stat;

   assert_one_answer_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(accept && reject));
   assert_no_latch_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (modify && !status[1]) |=> reject);
   assert_pin_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wrsr && status[7] && !wp_n) |=> (reject && !accept));
   assert_protected_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((cmd_pp || cmd_se) && hit && !status[0]) |=> !status[0]);
   assert_busy_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (modify && status[0]) |=> reject);
endmodule

// File: tb/flash_wprot_top_tb_top.sv
module flash_wprot_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_wren = 0, cmd_wrdi = 0, cmd_wrsr = 0, cmd_pp = 0, cmd_se = 0, cmd_ce = 0;
   logic        cmd_aux_on = 0, cmd_aux_off = 0, op_done = 0, wp_n = 1'b1;
   logic [7:0]  wr_data = '0;
   logic [21:0] addr = '0;
   logic [7:0]  status;
   logic        accept, reject, wel_clear, mode_aux;
   int          total = 0, bad = 0;
   bit          finished = 0;

   localparam int C_WREN = 0, C_WRDI = 1, C_WRSR = 2, C_PP = 3, C_SE = 4, C_CE = 5,
                  C_ON = 6, C_OFF = 7, C_DONE = 8;

   always #4 clk = ~clk;

   flash_wprot_top dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
      .cmd_wrsr(cmd_wrsr), .cmd_pp(cmd_pp), .cmd_se(cmd_se), .cmd_ce(cmd_ce),
      .cmd_aux_on(cmd_aux_on), .cmd_aux_off(cmd_aux_off), .wr_data(wr_data),
      .addr(addr), .wp_n(wp_n), .op_done(op_done), .status(status),
      .accept(accept), .reject(reject), .wel_clear(wel_clear), .mode_aux(mode_aux)
   );

   task automatic chk(input int act, input int exp, input string tag);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic send(input int c, input logic [21:0] a, input logic [7:0] d);
      addr = a; wr_data = d;
      cmd_wren = (c == C_WREN); cmd_wrdi = (c == C_WRDI); cmd_wrsr = (c == C_WRSR);
      cmd_pp = (c == C_PP); cmd_se = (c == C_SE); cmd_ce = (c == C_CE);
      cmd_aux_on = (c == C_ON); cmd_aux_off = (c == C_OFF); op_done = (c == C_DONE);
      @(negedge clk);
      {cmd_wren, cmd_wrdi, cmd_wrsr, cmd_pp, cmd_se, cmd_ce, cmd_aux_on, cmd_aux_off, op_done} = '0;
   endtask

   function automatic bit is_prot(input int lvl, input int sect);
      int cnt;
      cnt = (lvl == 0) ? 0 : ((lvl - 1 >= 6) ? 64 : (1 << (lvl - 1)));
      return sect >= 64 - cnt;
   endfunction

   task automatic set_level(input logic [7:0] d);
      send(C_WREN, '0, '0);
      send(C_WRSR, '0, d);
      send(C_DONE, '0, '0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] exp_s;
      repeat (3) @(negedge clk);
      chk(status, 8'h00, "R1 status");
      chk(mode_aux, 0, "R1 mode");
      chk({accept, reject}, 0, "R1 answers");
      rst_n = 1'b1;
      @(negedge clk);

      send(C_WREN, '0, '0);
      chk(status, 8'h02, "R2 wren");
      send(C_WRDI, '0, '0);
      chk(status, 8'h00, "R2 wrdi");

      for (int c = C_WRSR; c <= C_CE; c++) begin
         send(c, 22'h00_1000, 8'h9C);
         chk({accept, reject}, 2'b01, "R3 no latch");
         chk(status, 8'h00, "R3 unchanged");
      end

      for (int d = 0; d < 256; d++) begin
         exp_s = {d[7], 2'b00, d[4:2], 2'b00};
         send(C_WREN, '0, '0);
         send(C_WRSR, '0, 8'(d));
         chk({accept, reject}, 2'b10, "R4 wrsr accept");
         chk(status, exp_s | 8'h03, "R5 load");
         send(C_PP, '0, '0);
         chk({accept, reject}, 2'b01, "R8 busy reject");
         send(C_DONE, '0, '0);
         chk(status, exp_s, "R9 done clears");
         chk(wel_clear, 1, "R9 pulse");
         send(C_DONE, '0, '0);
         chk({status, wel_clear}, {exp_s, 1'b0}, "R9 idle done");
      end

      set_level(8'h80);
      chk(status, 8'h80, "R6 lock set");
      wp_n = 1'b0;
      send(C_WREN, '0, '0);
      send(C_WRSR, '0, 8'h00);
      chk({accept, reject}, 2'b01, "R6 pin lock");
      chk(status, 8'h82, "R6 frozen");
      wp_n = 1'b1;
      send(C_WRSR, '0, 8'h00);
      chk({accept, reject}, 2'b10, "R6 pin released");
      send(C_DONE, '0, '0);
      chk(status, 8'h00, "R6 cleared");

      for (int lvl = 0; lvl < 8; lvl++) begin
         set_level(8'(lvl << 2));
         for (int s = 0; s < 64; s++) begin
            for (int c = C_PP; c <= C_SE; c++) begin
               send(C_WREN, '0, '0);
               send(c, {6'(s), 16'h5A5A}, '0);
               if (is_prot(lvl, s)) begin
                  chk({accept, reject}, 2'b01, "R7 protected");
                  chk(status[0], 0, "R7 no busy");
                  send(C_WRDI, '0, '0);
               end else begin
                  chk({accept, reject}, 2'b10, "R7 open");
                  chk(status[0], 1, "R7 busy");
                  send(C_DONE, '0, '0);
               end
            end
         end
         send(C_WREN, '0, '0);
         send(C_CE, '0, '0);
         chk({accept, reject}, (lvl == 0) ? 2'b10 : 2'b01, "R7 chip erase");
         send((lvl == 0) ? C_DONE : C_WRDI, '0, '0);
      end

      set_level(8'h00);
      send(C_ON, '0, '0);
      chk(mode_aux, 1, "R10 enter");
      send(C_OFF, '0, '0);
      chk(mode_aux, 0, "R10 exit");
      send(C_WREN, '0, '0);
      send(C_SE, '0, '0);
      send(C_ON, '0, '0);
      chk(mode_aux, 0, "R10 busy enter ignored");
      send(C_DONE, '0, '0);
      send(C_ON, '0, '0);
      chk(mode_aux, 1, "R10 enter idle");
      send(C_WREN, '0, '0);
      send(C_SE, '0, '0);
      send(C_OFF, '0, '0);
      chk(mode_aux, 1, "R10 busy exit ignored");
      send(C_DONE, '0, '0);

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule